// File: doc/BRIEF.md
# Calendar Alarm Comparator with Oscillator-Stop Flag

This unit sits next to a calendar time counter and watches its eight live fields: second, minute, hour, day of month, day of week, day of year, month and year. Software programs an alarm value for each field and a per-field exclusion mask. When every field that still takes part in the comparison matches, the unit latches a sticky alarm flag. Software clears that flag by writing a one to it.

The unit also monitors a slow time-base clock input against the system clock. It passes that input through a two-flop synchroniser, looks for edges, and counts the system clocks since the last edge. If the count reaches a programmable timeout, a sticky oscillator-fail flag is set. That flag is already set when the unit comes out of reset. It drives an interrupt line only while a separate enable bit is also set.

Software reaches all state through a word-addressed register port with a 4-bit address, a write strobe, 32-bit write data and 32-bit combinational read data.

Top module: `cal_alarm_unit`

## Requirements
- R1: Mask bit k excludes field k from the alarm comparison when 1 and includes it when 0. The field order is: 0 second, 1 minute, 2 hour, 3 day of month, 4 day of week, 5 day of year, 6 month, 7 year.
- R2: After reset, the mask and all eight alarm values read as zero. The timeout register reads TIMEOUT_DEF (64).
- R3: An alarm event occurs on a cycle where all unmasked fields equal their alarm values and no match was present on the previous cycle. The event sets `alarm_flag` at the next clock edge. If the flag is cleared while the match persists, the flag is not raised again.
- R4: When all eight mask bits are 1, no alarm event is ever generated.
- R5: The alarm flag is status bit 0. Writing 1 there clears it and writing 0 has no effect. A new event in the same cycle as the clear keeps the flag set.
- R6: The oscillator-fail flag is status bit 4 and reads as 1 after reset.
- R7: While edges keep arriving on `slow_clk_in` more often than the timeout, the oscillator-fail flag is not set. Once no edge has arrived for the timeout number of system clocks, the flag is set.
- R8: Writing 1 to status bit 4 clears the oscillator-fail flag. While the stop condition is present, that write has no effect and the flag stays set.
- R9: The oscillator-fail enable is bit 4 of the enable register and resets to 0. `osc_irq` is 1 exactly when both the oscillator-fail flag and the enable are 1.
- R10: Reserved bits read as 0, and writes to them are ignored. This covers mask bits 31:8, alarm bits above each field's width, status bits other than 0 and 4, and enable bits other than 4.
- R11: The register addresses are: 0 mask, 1 to 8 alarm values in field order, 9 status, 10 enable, 11 timeout. The timeout register uses bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_sec | input | 6 | Live second |
| now_min | input | 6 | Live minute |
| now_hour | input | 5 | Live hour |
| now_dom | input | 5 | Live day of month |
| now_dow | input | 3 | Live day of week |
| now_doy | input | 9 | Live day of year |
| now_mon | input | 4 | Live month |
| now_year | input | 12 | Live year |
| slow_clk_in | input | 1 | Slow time-base clock, asynchronous |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| alarm_flag | output | 1 | Sticky alarm flag |
| osc_irq | output | 1 | Oscillator-fail interrupt |

## Verification
The hardest case to reach is a write-one clear of the oscillator-fail flag while the slow input is still stopped. The bench freezes the slow toggle generator until the timeout has certainly passed, then issues the clear and expects the flag to hold. A similar edge case is a clear of the alarm flag while the match persists. The bench holds the time inputs on the alarm values across the clear, then breaks and restores the match to force a fresh event. Random masks and alarm values are set with a roughly even share of matching fields, so that partial matches with one excluded field come up often.

// File: rtl/cal_alarm_pkg.sv
// Package: shared sizes, field widths and register addresses of the
// calendar alarm unit. Assumes eight calendar fields, none wider than 12 bits.
package cal_alarm_pkg;
    localparam int unsigned NF   = 8;
    localparam int unsigned MAXW = 12;
    localparam int unsigned AW   = 4;
    localparam int unsigned DW   = 32;
    localparam int unsigned FIELD_W [NF] = '{6, 6, 5, 5, 3, 9, 4, 12};

    localparam logic [AW-1:0] A_MASK    = 4'd0;
    localparam logic [AW-1:0] A_ALM0    = 4'd1;
    localparam logic [AW-1:0] A_ALM_END = 4'd8;
    localparam logic [AW-1:0] A_STATUS  = 4'd9;
    localparam logic [AW-1:0] A_ENABLE  = 4'd10;
    localparam logic [AW-1:0] A_TIMEOUT = 4'd11;

    localparam int unsigned B_ALARM = 0;
    localparam int unsigned B_OSC   = 4;

    typedef logic [MAXW-1:0] field_t;
endpackage

// File: rtl/cal_field_match.sv
// Module: compares each live calendar field with its alarm value, applies
// the exclusion mask and reports a one-cycle event on a new full match.
// Assumes inputs are zero-padded to MAXW bits.
module cal_field_match
    import cal_alarm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  field_t        now_f [NF],
    input  field_t        alm_f [NF],
    input  logic [NF-1:0] mask,
    output logic          match_evt
);
    logic [NF-1:0] eq;
    logic          match_now;
    logic          match_q;

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        localparam int unsigned W = FIELD_W[i];
        // per-field equality on the field's own width
        assign eq[i] = (now_f[i][W-1:0] == alm_f[i][W-1:0]);
    end

    // full match needs at least one included field
    assign match_now = (~mask != '0) && ((eq | mask) == '1);

    // remember last cycle's match for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_now;
    end

    assign match_evt = match_now && !match_q;
endmodule

// File: rtl/cal_osc_watch.sv
// Module: synchronises the slow clock, detects its edges and counts system
// clocks since the last one; flags a stop once the count reaches timeout.
// Assumes the slow clock is much slower than the system clock.
module cal_osc_watch #(
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slow_in,
    input  logic [TO_W-1:0] timeout,
    output logic            stopped
);
    logic [1:0]      sync_q;
    logic            last_q;
    logic            edge_seen;
    logic [TO_W-1:0] idle_cnt;

    // two-flop synchroniser plus a history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], slow_in};
            last_q <= sync_q[1];
        end
    end

    assign edge_seen = sync_q[1] ^ last_q;

    // saturating count of system clocks since the last slow edge
    always_ff @(posedge clk) begin
        if (!rst_n)                idle_cnt <= '0;
        else if (edge_seen)        idle_cnt <= '0;
        else if (idle_cnt != '1)   idle_cnt <= idle_cnt + 1'b1;
    end

    assign stopped = (idle_cnt >= timeout);
endmodule

// File: rtl/cal_alarm_regs.sv
// Module: register file for mask, alarm values, status flags, enable and
// timeout; the flags are sticky and cleared by write-one, and a set wins.
// Assumes single-cycle writes and combinational reads.
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int unsigned TO_W        = 16,
    parameter int unsigned TIMEOUT_DEF = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic            alarm_evt,
    input  logic            osc_stop,
    output logic [NF-1:0]   mask,
    output field_t          alm_f [NF],
    output logic [TO_W-1:0] timeout,
    output logic            osc_en,
    output logic            osc_flag,
    output logic            alarm_flag
);
    logic wr_status;
    assign wr_status = we && (addr == A_STATUS);

    // mask, enable and timeout registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '0;
            osc_en  <= 1'b0;
            timeout <= TO_W'(TIMEOUT_DEF);
        end else if (we) begin
            if (addr == A_MASK)    mask    <= wdata[NF-1:0];
            if (addr == A_ENABLE)  osc_en  <= wdata[B_OSC];
            if (addr == A_TIMEOUT) timeout <= wdata[TO_W-1:0];
        end
    end

    for (genvar i = 0; i < NF; i++) begin : g_alm
        localparam field_t FMASK = field_t'((1 << FIELD_W[i]) - 1);
        // alarm value register, trimmed to the field width
        always_ff @(posedge clk) begin
            if (!rst_n)                                  alm_f[i] <= '0;
            else if (we && addr == A_ALM0 + AW'(i))      alm_f[i] <= wdata[MAXW-1:0] & FMASK;
        end
    end

    // sticky alarm flag: event sets, write-one clears, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                            alarm_flag <= 1'b0;
        else if (alarm_evt)                    alarm_flag <= 1'b1;
        else if (wr_status && wdata[B_ALARM])  alarm_flag <= 1'b0;
    end

    // sticky oscillator-fail flag: set at reset, detection beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)                          osc_flag <= 1'b1;
        else if (osc_stop)                   osc_flag <= 1'b1;
        else if (wr_status && wdata[B_OSC])  osc_flag <= 1'b0;
    end

    // read multiplexer, reserved bits return zero
    always_comb begin
        rdata = '0;
        if (addr == A_MASK) begin
            rdata[NF-1:0] = mask;
        end else if (addr >= A_ALM0 && addr <= A_ALM_END) begin
            rdata[MAXW-1:0] = alm_f[3'(addr - A_ALM0)];
        end else if (addr == A_STATUS) begin
            rdata[B_ALARM] = alarm_flag;
            rdata[B_OSC]   = osc_flag;
        end else if (addr == A_ENABLE) begin
            rdata[B_OSC] = osc_en;
        end else if (addr == A_TIMEOUT) begin
            rdata[TO_W-1:0] = timeout;
        end
    end
endmodule

// File: rtl/cal_alarm_unit.sv
// Module: top of the calendar alarm unit; packs the live time fields,
// and connects the comparator, the oscillator watch and the register file.
// Assumes the time inputs are synchronous to clk.
module cal_alarm_unit
    import cal_alarm_pkg::*;
#(
    parameter int unsigned TO_W        = 16,
    parameter int unsigned TIMEOUT_DEF = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    now_sec,
    input  logic [5:0]    now_min,
    input  logic [4:0]    now_hour,
    input  logic [4:0]    now_dom,
    input  logic [2:0]    now_dow,
    input  logic [8:0]    now_doy,
    input  logic [3:0]    now_mon,
    input  logic [11:0]   now_year,
    input  logic          slow_clk_in,
    input  logic [3:0]    reg_addr,
    input  logic          reg_we,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          alarm_flag,
    output logic          osc_irq
);
    field_t          now_f [NF];
    field_t          alm_f [NF];
    logic [NF-1:0]   mask;
    logic [TO_W-1:0] timeout;
    logic            alarm_evt;
    logic            stopped;
    logic            osc_en;
    logic            osc_flag;

    // zero-pad the live fields into the common field array
    assign now_f[0] = field_t'(now_sec);
    assign now_f[1] = field_t'(now_min);
    assign now_f[2] = field_t'(now_hour);
    assign now_f[3] = field_t'(now_dom);
    assign now_f[4] = field_t'(now_dow);
    assign now_f[5] = field_t'(now_doy);
    assign now_f[6] = field_t'(now_mon);
    assign now_f[7] = field_t'(now_year);

    cal_field_match u_match (
        .clk(clk), .rst_n(rst_n), .now_f(now_f), .alm_f(alm_f),
        .mask(mask), .match_evt(alarm_evt)
    );

    cal_osc_watch #(.TO_W(TO_W)) u_osc (
        .clk(clk), .rst_n(rst_n), .slow_in(slow_clk_in),
        .timeout(timeout), .stopped(stopped)
    );

    cal_alarm_regs #(.TO_W(TO_W), .TIMEOUT_DEF(TIMEOUT_DEF)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .rdata(reg_rdata), .alarm_evt(alarm_evt),
        .osc_stop(stopped), .mask(mask), .alm_f(alm_f), .timeout(timeout),
        .osc_en(osc_en), .osc_flag(osc_flag), .alarm_flag(alarm_flag)
    );

    // interrupt only while flag and enable are both set
    assign osc_irq = osc_flag && osc_en;
endmodule

// File: rtl/cal_alarm_checker.sv
// Module: property checker bound to the alarm unit top.
// Assumes the bind connects the named internal nets of the top.
module cal_alarm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        alarm_flag,
    input logic        osc_irq,
    input logic        osc_flag,
    input logic        osc_en,
    input logic [7:0]  mask,
    input logic        stopped,
    input logic        alarm_evt,
    input logic        reg_we,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata
);
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !osc_irq); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_flag |-> !osc_irq); // R9
    AST_STOP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> osc_flag); // R8
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'hFF && !alarm_flag) |=> !alarm_flag); // R4
    AST_EVT_SETS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> alarm_flag); // R3
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !(reg_we && reg_addr == 4'd9 && reg_wdata[0])) |=> alarm_flag); // R5
    AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'd9) |-> (reg_rdata[31:5] == '0 && reg_rdata[3:1] == '0)); // R10
endmodule

bind cal_alarm_unit cal_alarm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .alarm_flag(alarm_flag), .osc_irq(osc_irq),
    .osc_flag(osc_flag), .osc_en(osc_en), .mask(mask), .stopped(stopped),
    .alarm_evt(alarm_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/cal_alarm_unit_test.sv
// Bench: random masks, alarm values and time inputs, with directed corner
// cases, checked against a model of the requirements.
module cal_alarm_unit_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NFL = 8;
    localparam int  FW [NFL] = '{6, 6, 5, 5, 3, 9, 4, 12};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  now_sec = 6'd1;
    logic [5:0]  now_min = 6'd0;
    logic [4:0]  now_hour = 5'd0;
    logic [4:0]  now_dom = 5'd0;
    logic [2:0]  now_dow = 3'd0;
    logic [8:0]  now_doy = 9'd0;
    logic [3:0]  now_mon = 4'd0;
    logic [11:0] now_year = 12'd0;
    logic        slow_clk_in = 1'b0;
    logic        osc_run = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        alarm_flag;
    logic        osc_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int unsigned e_alm [NFL];
    logic [7:0]  e_mask = '0;
    logic        e_flag = 1'b0;
    logic        e_prev = 1'b0;

    cal_alarm_unit uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // slow clock generator, toggles every 6 system clocks while running
    initial forever begin
        repeat (6) @(negedge clk);
        if (osc_run) slow_clk_in = ~slow_clk_in;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic int unsigned now_val(int i);
        case (i)
            0: return now_sec;   1: return now_min;
            2: return now_hour;  3: return now_dom;
            4: return now_dow;   5: return now_doy;
            6: return now_mon;   default: return now_year;
        endcase
    endfunction

    function automatic logic model_match();
        logic all_eq = 1'b1;
        if (e_mask == 8'hFF) return 1'b0;
        for (int i = 0; i < NFL; i++)
            if (!e_mask[i] && now_val(i) != e_alm[i]) all_eq = 1'b0;
        return all_eq;
    endfunction

    task automatic set_now(int i, int unsigned v);
        case (i)
            0: now_sec = 6'(v);   1: now_min = 6'(v);
            2: now_hour = 5'(v);  3: now_dom = 5'(v);
            4: now_dow = 3'(v);   5: now_doy = 9'(v);
            6: now_mon = 4'(v);   default: now_year = 12'(v);
        endcase
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock edge with the alarm model updated from pre-edge state
    task automatic tick();
        logic m;
        m = model_match();
        @(posedge clk);
        if (m && !e_prev) e_flag = 1'b1;
        else if (reg_we && reg_addr == 4'd9 && reg_wdata[0]) e_flag = 1'b0;
        e_prev = m;
        if (reg_we && reg_addr == 4'd0) e_mask = reg_wdata[7:0];
        if (reg_we && reg_addr >= 4'd1 && reg_addr <= 4'd8)
            e_alm[reg_addr-1] = reg_wdata & ((32'd1 << FW[reg_addr-1]) - 1);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < NFL; i++) e_alm[i] = 0;
        repeat (3) @(negedge clk);
        // reset-state checks while reset is held
        check("R5 alarm flag in reset", {31'b0, alarm_flag}, 32'd0);
        rst_n = 1'b1;
        rd(4'd9, v);  check("R6 status after reset", v, 32'h10);
        rd(4'd0, v);  check("R2 mask after reset", v, 32'h0);
        rd(4'd8, v);  check("R2 year alarm after reset", v, 32'h0);
        rd(4'd11, v); check("R2 timeout after reset", v, 32'd64);
        rd(4'd10, v); check("R9 enable after reset", v, 32'h0);
        check("R9 irq off with enable 0", {31'b0, osc_irq}, 32'd0);

        // reserved bits are ignored
        wr(4'd0, 32'hFFFF_FF00); rd(4'd0, v); check("R10 mask upper bits", v, 32'h0);
        wr(4'd10, 32'hFFFF_FFEF); rd(4'd10, v); check("R10 enable reserved", v, 32'h0);
        wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, v); check("R10 dow alarm width", v, 32'h7);
        wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, v); check("R11 doy alarm at 6", v, 32'h1FF);

        // clear oscillator flag while the slow clock runs
        wr(4'd9, 32'h10); rd(4'd9, v); check("R8 osc flag cleared", v & 32'h10, 32'h0);

        // directed: match, clear while match persists, re-arm
        for (int i = 0; i < NFL; i++) wr(4'(i + 1), 32'(i + 2));
        wr(4'd9, 32'h1);
        for (int i = 0; i < NFL; i++) set_now(i, i + 2);
        tick();
        check("R3 full match sets flag", {31'b0, alarm_flag}, {31'b0, e_flag});
        wr(4'd9, 32'h0); check("R5 write 0 no effect", {31'b0, alarm_flag}, 32'd1);
        wr(4'd9, 32'h1); tick(); tick();
        check("R3 no re-raise while match held", {31'b0, alarm_flag}, 32'd0);
        now_sec = 6'd40; tick(); now_sec = 6'd2; tick();
        check("R3 new event after break", {31'b0, alarm_flag}, 32'd1);
        // all masked
        wr(4'd0, 32'hFF); wr(4'd9, 32'h1); now_sec = 6'd3; tick(); now_sec = 6'd2; tick();
        check("R4 all masked no alarm", {31'b0, alarm_flag}, 32'd0);

        // random phase
        for (int it = 0; it < 60; it++) begin
            logic [7:0] m;
            m = ($urandom % 8 == 0) ? 8'hFF : 8'($urandom);
            wr(4'd0, {24'b0, m});
            for (int i = 0; i < NFL; i++) wr(4'(i + 1), $urandom);
            wr(4'd9, 32'h1);
            check("R5 flag cleared", {31'b0, alarm_flag}, {31'b0, e_flag});
            for (int s = 0; s < 6; s++) begin
                for (int i = 0; i < NFL; i++)
                    set_now(i, ($urandom % 3 != 0) ? e_alm[i] : $urandom);
                tick();
                check(m == 8'hFF ? "R4 random masked" : "R1 random compare",
                      {31'b0, alarm_flag}, {31'b0, e_flag});
            end
        end

        // oscillator: running within timeout keeps flag clear
        wr(4'd11, 32'd20); wr(4'd9, 32'h10);
        repeat (80) tick();
        rd(4'd9, v); check("R7 running no fail", v & 32'h10, 32'h0);
        osc_run = 1'b0;
        repeat (40) tick();
        rd(4'd9, v); check("R7 stop sets fail", v & 32'h10, 32'h10);
        check("R9 irq off enable 0", {31'b0, osc_irq}, 32'd0);
        wr(4'd10, 32'h10);
        check("R9 irq on flag and enable", {31'b0, osc_irq}, 32'd1);
        wr(4'd9, 32'h10); rd(4'd9, v);
        check("R8 clear ignored while stopped", v & 32'h10, 32'h10);
        osc_run = 1'b1;
        repeat (20) tick();
        wr(4'd9, 32'h10);
        repeat (60) tick();
        rd(4'd9, v); check("R8 clear after restart", v & 32'h10, 32'h0);
        check("R9 irq off flag 0", {31'b0, osc_irq}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule